// File: doc/BRIEF.md
# Registered Parity Bus Transceiver

This block moves byte-wide words between an A side and a B side in both directions at once. Each direction carries several independent lanes. Each lane holds eight data bits and one parity bit. Every lane in every direction passes through one storage stage. That stage follows its input while the direction's latch enable is high. It holds its contents while the latch enable is low. It reloads on a rising edge of the direction's clock when the lane's active-low clock enable is asserted.

A shared mode input picks between two behaviours. In generate mode, a fresh parity bit is computed for each outgoing word and each incoming word is checked, with a per-lane error flag for each side. In feedthrough mode, data and parity cross unchanged and the error flags stay low. A shared sense input selects odd or even parity for both generation and checking. Each direction has an output enable, and a disabled direction drives all-zero data and parity. The words cross with fixed timing, so no back-pressure is applied at either side. The only gating is the output enable.

Top module: `rpt_transceiver`

## Requirements
- R1: When le_ab and oe_ab are both high, b_data_o equals a_data_i within the same cycle (transparent path).
- R2: When le_ab is low and clken_ab_n[l] is low, a rising clk_ab edge stores lane l's A input word (data plus parity), and that word appears at the B outputs after the edge.
- R3: When le_ab is low and clken_ab_n[l] is high, lane l's B outputs keep their value across clk_ab edges whatever the inputs do.
- R4: When gen_mode=1, each output parity bit is recomputed from the data leaving storage. With it, the 9-bit output word of that lane has an odd count of ones when odd_mode=1 and an even count when odd_mode=0.
- R5: When gen_mode=0, each output parity bit is the parity input carried through the same storage path as its data, and every error output is 0.
- R6: When gen_mode=1, err_a_o[l] is 1 exactly when a_data_i lane l together with a_par_i[l] breaks the selected sense, and err_b_o[l] does the same for the B inputs. The flag is combinational on the raw inputs and does not depend on storage.
- R7: While oe_ab is low, b_data_o and b_par_o are all zero. Storage keeps working, and a word captured while the outputs were disabled appears once oe_ab returns high. oe_ba acts the same way on the A outputs.
- R8: An active-low asynchronous reset rst_n clears every stored word to zero.
- R9: The B-to-A direction behaves as in R1 to R3 using le_ba, clk_ba, clken_ba_n and oe_ba, independently of the A-to-B controls.
- R10: Lane l occupies bits [8l+7:8l] of each data bus and bit l of each parity, error and clock-enable bus. A lane's clock enable affects only that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Clock for A-to-B storage |
| clk_ba | input | 1 | Clock for B-to-A storage |
| rst_n | input | 1 | Asynchronous reset, active low |
| gen_mode | input | 1 | 1 = generate and check parity, 0 = feedthrough |
| odd_mode | input | 1 | 1 = odd parity, 0 = even parity |
| le_ab | input | 1 | A-to-B latch enable (high = transparent) |
| clken_ab_n | input | LANES | A-to-B per-lane clock enable, active low |
| oe_ab | input | 1 | Output enable for the B outputs |
| le_ba | input | 1 | B-to-A latch enable (high = transparent) |
| clken_ba_n | input | LANES | B-to-A per-lane clock enable, active low |
| oe_ba | input | 1 | Output enable for the A outputs |
| a_data_i | input | LANES*LANE_W | A-side incoming data |
| a_par_i | input | LANES | A-side incoming parity |
| b_data_i | input | LANES*LANE_W | B-side incoming data |
| b_par_i | input | LANES | B-side incoming parity |
| b_data_o | output | LANES*LANE_W | B-side outgoing data |
| b_par_o | output | LANES | B-side outgoing parity |
| err_a_o | output | LANES | Parity error on the A-side incoming lanes |
| a_data_o | output | LANES*LANE_W | A-side outgoing data |
| a_par_o | output | LANES | A-side outgoing parity |
| err_b_o | output | LANES | Parity error on the B-side incoming lanes |

## Verification
The assertions check these rules on every cycle:
- the transparent path;
- loading and holding of each lane across edges;
- the parity sense of every enabled outgoing word;
- the all-zero outputs while disabled;
- quiet error flags and passed-through parity in feedthrough mode.

Only the bench's scenarios show the remaining behaviours:
- that the error flags fire exactly on single-bit corruption of any of the nine bits;
- that a word captured while the outputs were disabled reappears on re-enable;
- that the two directions and the two lanes really act apart under mixed control settings.

// File: rtl/rpt_pkg.sv
`timescale 1ns/1ps
package rpt_pkg;
  localparam int unsigned DEF_LANES  = 2;
  localparam int unsigned DEF_LANE_W = 8;

  typedef enum logic {SENSE_EVEN = 1'b0, SENSE_ODD = 1'b1} sense_e;
  typedef enum logic {PATH_FEED = 1'b0, PATH_GEN = 1'b1} path_e;
endpackage

// File: rtl/rpt_lane_store.sv
`timescale 1ns/1ps
module rpt_lane_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic         clken_n,
  input  logic [W-1:0] d_i,
  input  logic         p_i,
  output logic [W-1:0] d_o,
  output logic         p_o
);
  localparam int unsigned WW = W + 1;

  logic [WW-1:0] word_q;
  logic [WW-1:0] word_in;
  logic          load;

  assign word_in = {p_i, d_i};
  assign load    = le || !clken_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (load) begin
      word_q <= word_in;
    end
  end

  assign {p_o, d_o} = le ? word_in : word_q;
endmodule

// File: rtl/rpt_parity_unit.sv
`timescale 1ns/1ps
module rpt_parity_unit
  import rpt_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  sense_e       sense,
  input  path_e        path,
  input  logic [W-1:0] rx_d,
  input  logic         rx_p,
  input  logic [W-1:0] tx_d,
  input  logic         tx_p,
  output logic         tx_par_o,
  output logic         err_o
);
  logic rx_ones_odd;
  logic sense_bit;
  logic gen_bit;

  assign sense_bit   = (sense == SENSE_ODD);
  assign rx_ones_odd = ^{rx_d, rx_p};
  assign gen_bit     = (^tx_d) ^ sense_bit;

  always_comb begin
    if (path == PATH_GEN) begin
      tx_par_o = gen_bit;
      err_o    = (rx_ones_odd != sense_bit);
    end else begin
      tx_par_o = tx_p;
      err_o    = 1'b0;
    end
  end
endmodule

// File: rtl/rpt_direction.sv
`timescale 1ns/1ps
module rpt_direction
  import rpt_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned LANE_W = DEF_LANE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    le,
  input  logic [LANES-1:0]        clken_n,
  input  logic                    oe,
  input  sense_e                  sense,
  input  path_e                   path,
  input  logic [LANES*LANE_W-1:0] in_d,
  input  logic [LANES-1:0]        in_p,
  output logic [LANES*LANE_W-1:0] out_d,
  output logic [LANES-1:0]        out_p,
  output logic [LANES-1:0]        err
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int unsigned LO = l * LANE_W;

    logic [LANE_W-1:0] st_d;
    logic              st_p;
    logic              tx_par;

    rpt_lane_store #(.W(LANE_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .le      (le),
      .clken_n (clken_n[l]),
      .d_i     (in_d[LO +: LANE_W]),
      .p_i     (in_p[l]),
      .d_o     (st_d),
      .p_o     (st_p)
    );

    rpt_parity_unit #(.W(LANE_W)) u_par (
      .sense    (sense),
      .path     (path),
      .rx_d     (in_d[LO +: LANE_W]),
      .rx_p     (in_p[l]),
      .tx_d     (st_d),
      .tx_p     (st_p),
      .tx_par_o (tx_par),
      .err_o    (err[l])
    );

    assign out_d[LO +: LANE_W] = oe ? st_d : '0;
    assign out_p[l]            = oe ? tx_par : 1'b0;
  end
endmodule

// File: rtl/rpt_transceiver.sv
`timescale 1ns/1ps
module rpt_transceiver
  import rpt_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned LANE_W = DEF_LANE_W,
  localparam int unsigned BUS_W = LANES * LANE_W
) (
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             rst_n,
  input  logic             gen_mode,
  input  logic             odd_mode,
  input  logic             le_ab,
  input  logic [LANES-1:0] clken_ab_n,
  input  logic             oe_ab,
  input  logic             le_ba,
  input  logic [LANES-1:0] clken_ba_n,
  input  logic             oe_ba,
  input  logic [BUS_W-1:0] a_data_i,
  input  logic [LANES-1:0] a_par_i,
  input  logic [BUS_W-1:0] b_data_i,
  input  logic [LANES-1:0] b_par_i,
  output logic [BUS_W-1:0] b_data_o,
  output logic [LANES-1:0] b_par_o,
  output logic [LANES-1:0] err_a_o,
  output logic [BUS_W-1:0] a_data_o,
  output logic [LANES-1:0] a_par_o,
  output logic [LANES-1:0] err_b_o
);
  sense_e sense;
  path_e  path;

  assign sense = sense_e'(odd_mode);
  assign path  = path_e'(gen_mode);

  rpt_direction #(.LANES(LANES), .LANE_W(LANE_W)) u_a2b (
    .clk     (clk_ab),
    .rst_n   (rst_n),
    .le      (le_ab),
    .clken_n (clken_ab_n),
    .oe      (oe_ab),
    .sense   (sense),
    .path    (path),
    .in_d    (a_data_i),
    .in_p    (a_par_i),
    .out_d   (b_data_o),
    .out_p   (b_par_o),
    .err     (err_a_o)
  );

  rpt_direction #(.LANES(LANES), .LANE_W(LANE_W)) u_b2a (
    .clk     (clk_ba),
    .rst_n   (rst_n),
    .le      (le_ba),
    .clken_n (clken_ba_n),
    .oe      (oe_ba),
    .sense   (sense),
    .path    (path),
    .in_d    (b_data_i),
    .in_p    (b_par_i),
    .out_d   (a_data_o),
    .out_p   (a_par_o),
    .err     (err_b_o)
  );
endmodule

// File: rtl/rpt_transceiver_chk.sv
`timescale 1ns/1ps
module rpt_transceiver_chk #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned BUS_W = LANES * LANE_W
) (
  input logic             clk_ab,
  input logic             clk_ba,
  input logic             rst_n,
  input logic             gen_mode,
  input logic             odd_mode,
  input logic             le_ab,
  input logic [LANES-1:0] clken_ab_n,
  input logic             oe_ab,
  input logic             le_ba,
  input logic [LANES-1:0] clken_ba_n,
  input logic             oe_ba,
  input logic [BUS_W-1:0] a_data_i,
  input logic [LANES-1:0] a_par_i,
  input logic [BUS_W-1:0] b_data_i,
  input logic [LANES-1:0] b_par_i,
  input logic [BUS_W-1:0] b_data_o,
  input logic [LANES-1:0] b_par_o,
  input logic [LANES-1:0] err_a_o,
  input logic [BUS_W-1:0] a_data_o,
  input logic [LANES-1:0] a_par_o,
  input logic [LANES-1:0] err_b_o
);
  assert_transparent_ab_R1: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (le_ab && oe_ab) |-> (b_data_o == a_data_i));
  assert_transparent_ba_R9: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (le_ba && oe_ba) |-> (a_data_o == b_data_i));

  assert_feed_par_ab_R5: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!gen_mode && le_ab && oe_ab) |-> (b_par_o == a_par_i));
  assert_feed_par_ba_R5: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (!gen_mode && le_ba && oe_ba) |-> (a_par_o == b_par_i));
  assert_feed_quiet_R5: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !gen_mode |-> (err_a_o == '0 && err_b_o == '0));

  assert_disabled_ab_R7: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !oe_ab |-> (b_data_o == '0 && b_par_o == '0));
  assert_disabled_ba_R7: assert property (@(posedge clk_ba) disable iff (!rst_n)
    !oe_ba |-> (a_data_o == '0 && a_par_o == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int unsigned LO = l * LANE_W;

    assert_capture_ab_R2: assert property (@(posedge clk_ab) disable iff (!rst_n)
      (!le_ab && !clken_ab_n[l]) |=>
        (le_ab || !oe_ab || b_data_o[LO +: LANE_W] == $past(a_data_i[LO +: LANE_W])));
    assert_capture_ba_R9: assert property (@(posedge clk_ba) disable iff (!rst_n)
      (!le_ba && !clken_ba_n[l]) |=>
        (le_ba || !oe_ba || a_data_o[LO +: LANE_W] == $past(b_data_i[LO +: LANE_W])));

    assert_hold_ab_R3: assert property (@(posedge clk_ab) disable iff (!rst_n)
      (!le_ab && clken_ab_n[l]) |=>
        (le_ab || !oe_ab || !$past(oe_ab) || $stable(b_data_o[LO +: LANE_W])));
    assert_hold_ba_R10: assert property (@(posedge clk_ba) disable iff (!rst_n)
      (!le_ba && clken_ba_n[l]) |=>
        (le_ba || !oe_ba || !$past(oe_ba) || $stable(a_data_o[LO +: LANE_W])));

    assert_gen_sense_ab_R4: assert property (@(posedge clk_ab) disable iff (!rst_n)
      (gen_mode && oe_ab) |-> ((^{b_data_o[LO +: LANE_W], b_par_o[l]}) == odd_mode));
    assert_gen_sense_ba_R4: assert property (@(posedge clk_ba) disable iff (!rst_n)
      (gen_mode && oe_ba) |-> ((^{a_data_o[LO +: LANE_W], a_par_o[l]}) == odd_mode));
  end
endmodule

bind rpt_transceiver rpt_transceiver_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/rpt_transceiver_test.sv
`timescale 1ns/1ps
module rpt_transceiver_test;
  localparam int L = 2;
  localparam int W = 8;
  localparam int N = L * W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, gen_mode, odd_mode;
  logic le_ab, oe_ab, le_ba, oe_ba;
  logic [L-1:0] clken_ab_n, clken_ba_n;
  logic [N-1:0] a_data_i, b_data_i, b_data_o, a_data_o;
  logic [L-1:0] a_par_i, b_par_i, b_par_o, a_par_o, err_a_o, err_b_o;

  int checks = 0;
  int fails  = 0;

  rpt_transceiver #(.LANES(L), .LANE_W(W)) uut (
    .clk_ab(clk), .clk_ba(clk), .rst_n(rst_n),
    .gen_mode(gen_mode), .odd_mode(odd_mode),
    .le_ab(le_ab), .clken_ab_n(clken_ab_n), .oe_ab(oe_ab),
    .le_ba(le_ba), .clken_ba_n(clken_ba_n), .oe_ba(oe_ba),
    .a_data_i(a_data_i), .a_par_i(a_par_i),
    .b_data_i(b_data_i), .b_par_i(b_par_i),
    .b_data_o(b_data_o), .b_par_o(b_par_o), .err_a_o(err_a_o),
    .a_data_o(a_data_o), .a_par_o(a_par_o), .err_b_o(err_b_o)
  );

  // Reference storage, one word per lane per direction
  logic [N-1:0] m_ab_d, m_ba_d;
  logic [L-1:0] m_ab_p, m_ba_p;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ab_d <= '0; m_ab_p <= '0; m_ba_d <= '0; m_ba_p <= '0;
    end else begin
      for (int l = 0; l < L; l++) begin
        if (le_ab || !clken_ab_n[l]) begin
          m_ab_d[l*W +: W] <= a_data_i[l*W +: W];
          m_ab_p[l]        <= a_par_i[l];
        end
        if (le_ba || !clken_ba_n[l]) begin
          m_ba_d[l*W +: W] <= b_data_i[l*W +: W];
          m_ba_p[l]        <= b_par_i[l];
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic expect_dir(input logic le, input logic oe,
                            input logic [N-1:0] id, input logic [L-1:0] ip,
                            input logic [N-1:0] md, input logic [L-1:0] mp,
                            output logic [N-1:0] od, output logic [L-1:0] op,
                            output logic [L-1:0] oerr);
    for (int l = 0; l < L; l++) begin
      logic [W-1:0] d;
      logic p;
      int ones;
      d = le ? id[l*W +: W] : md[l*W +: W];
      p = le ? ip[l] : mp[l];
      ones = $countones(d);
      if (gen_mode) p = ((ones % 2) == 1) ? !odd_mode : odd_mode;
      od[l*W +: W] = oe ? d : '0;
      op[l] = oe ? p : 1'b0;
      ones = $countones(id[l*W +: W]) + int'(ip[l]);
      oerr[l] = gen_mode && (((ones % 2) == 1) != odd_mode);
    end
  endtask

  task automatic check_all(input string req);
    logic [N-1:0] ed;
    logic [L-1:0] ep, ee;
    expect_dir(le_ab, oe_ab, a_data_i, a_par_i, m_ab_d, m_ab_p, ed, ep, ee);
    chk(req, "b_data", b_data_o, ed);
    chk(req, "b_par", N'(b_par_o), N'(ep));
    chk(req, "err_a", N'(err_a_o), N'(ee));
    expect_dir(le_ba, oe_ba, b_data_i, b_par_i, m_ba_d, m_ba_p, ed, ep, ee);
    chk(req, "a_data", a_data_o, ed);
    chk(req, "a_par", N'(a_par_o), N'(ep));
    chk(req, "err_b", N'(err_b_o), N'(ee));
  endtask

  task automatic rnd_inputs();
    a_data_i = N'($urandom); b_data_i = N'($urandom);
    a_par_i = L'($urandom); b_par_i = L'($urandom);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; gen_mode = 1'b0; odd_mode = 1'b0;
    le_ab = 1'b0; le_ba = 1'b0; oe_ab = 1'b0; oe_ba = 1'b0;
    clken_ab_n = '1; clken_ba_n = '1;
    a_data_i = '0; b_data_i = '0; a_par_i = '0; b_par_i = '0;

    // R8 / R7: reset with outputs disabled
    repeat (3) @(negedge clk);
    #1 check_all("R8/R7");
    @(negedge clk);
    rst_n = 1'b1; oe_ab = 1'b1; oe_ba = 1'b1;
    a_data_i = '1; b_data_i = 16'h5AA5; a_par_i = '1; b_par_i = '1;
    #1 check_all("R8");
    @(negedge clk);
    #1 check_all("R8");

    // R1/R4/R5/R6: transparent sweep over every byte, both modes and senses
    le_ab = 1'b1; le_ba = 1'b1;
    for (int g = 0; g < 2; g++) begin
      for (int o = 0; o < 2; o++) begin
        gen_mode = g[0]; odd_mode = o[0];
        for (int v = 0; v < 256; v++) begin
          @(negedge clk);
          a_data_i = {8'(v) ^ 8'h5A, 8'(v)};
          b_data_i = ~{8'(v), 8'(255 - v)};
          a_par_i  = {v[3], v[0]};
          b_par_i  = {v[1], v[2]};
          #1 check_all(g ? "R1/R4/R6" : "R1/R5/R9");
        end
      end
    end

    // R6: single-bit corruption of each of the nine bits, one lane at a time
    gen_mode = 1'b1;
    for (int o = 0; o < 2; o++) begin
      odd_mode = o[0];
      for (int rep = 0; rep < 8; rep++) begin
        for (int k = 0; k < W + 1; k++) begin
          for (int lane = 0; lane < L; lane++) begin
            @(negedge clk);
            a_data_i = N'($urandom); b_data_i = N'($urandom);
            for (int l = 0; l < L; l++) begin
              a_par_i[l] = (^a_data_i[l*W +: W]) ^ odd_mode;
              b_par_i[l] = (^b_data_i[l*W +: W]) ^ odd_mode;
            end
            #1 check_all("R6");
            if (k < W) begin
              a_data_i[lane*W + k] = ~a_data_i[lane*W + k];
              b_data_i[lane*W + k] = ~b_data_i[lane*W + k];
            end else begin
              a_par_i[lane] = ~a_par_i[lane];
              b_par_i[lane] = ~b_par_i[lane];
            end
            #1 check_all("R6");
          end
        end
      end
    end

    // R2/R9: clocked capture in both directions, random modes
    le_ab = 1'b0; le_ba = 1'b0; clken_ab_n = '0; clken_ba_n = '0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      gen_mode = 1'($urandom); odd_mode = 1'($urandom);
      rnd_inputs();
      #1 check_all("R2/R9/R4");
    end

    // R9/R3: A-to-B transparent while B-to-A holds
    le_ab = 1'b1; clken_ba_n = '1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      gen_mode = 1'($urandom); odd_mode = 1'($urandom);
      rnd_inputs();
      #1 check_all("R9/R3");
    end

    // R3/R10: per-lane clock enables, opposite lanes per direction
    le_ab = 1'b0; le_ba = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      clken_ab_n = (i < 100) ? 2'b10 : 2'b01;
      clken_ba_n = ~clken_ab_n;
      gen_mode = 1'($urandom); odd_mode = 1'($urandom);
      rnd_inputs();
      #1 check_all("R3/R10");
    end

    // R7: capture while disabled, then re-enable with storage held
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      oe_ab = 1'b0; oe_ba = 1'b0; clken_ab_n = '0; clken_ba_n = '0;
      gen_mode = 1'($urandom); odd_mode = 1'($urandom);
      rnd_inputs();
      #1 check_all("R7");
      @(negedge clk);
      oe_ab = 1'b1; oe_ba = 1'b1; clken_ab_n = '1; clken_ba_n = '1;
      rnd_inputs();
      #1 check_all("R7");
    end

    // R8: reset mid-run clears stored words
    @(negedge clk);
    rst_n = 1'b0;
    #1 check_all("R8");
    @(negedge clk);
    rst_n = 1'b1;
    #1 check_all("R8");

    finish_run();
  end
endmodule